// File: doc/BRIEF.md
# Daisy-Chain Serial Channel Selector

This block is the serial target front end of a device that serves a fixed number of line channels (two by default) and sits in a chain of identical devices. The host drives one clock, one chip select and one data line. Each device passes the data line on to the next device through `sdi_thru`, so every device sees the same frame at the same time. A frame carries a header (four command bits, then a channel number, then an address) followed by a data word of 8 or 16 bits.

The device does not compare the channel number against a strap. Each channel inside the node takes one off the number as it streams past, LSB first, and the channel that sees zero is the one addressed. The next device therefore receives the number reduced by the channel count, in the same clock slot. A broadcast write passes the number through untouched and is taken by every channel. For a read aimed at one of its own channels the node drives `sdo` with the word supplied on `rd_data`. At all other times it holds the output-enable low so that the pad can float the shared return line.

Top module: `daisy_spi_node`

## Requirements
- R1: Frame layout, one bit per rising `sclk` edge while `cs_n` is low: slot 0 broadcast flag, slot 1 direction (1 = read, 0 = write), slot 2 space select (1 = register, 0 = RAM), slot 3 reserved, slots 4..7 channel number LSB first, slots 8..15 address MSB first, then the data word MSB first. `acc_read`, `acc_reg` and `acc_addr` report the captured fields.
- R2: Outside broadcast, `sdi_thru` carries the channel number reduced by the channel count (modulo 16, LSB first) in the same clock slot as `sdi`. Every other slot is copied from `sdi` unchanged.
- R3: With broadcast clear, channel 0 is addressed when the received number is 0 and channel 1 when it is 1. This sets `tgt_mask` bit 0 or bit 1, and at most one bit is set. Any other number leaves the mask at zero.
- R4: With broadcast set, the channel number is forwarded unchanged and `tgt_mask` is all ones.
- R5: A broadcast read never raises `sdo_oe`.
- R6: `sdo_oe` is low and `sdo` is 0 during the 16 header slots, after the data phase, and for any frame that is not a read aimed at one of this node's channels.
- R7: For a read aimed at this node, `sdo_oe` is high for exactly the data slots: 16 when `len16` is 1, 8 when it is 0. `sdo` presents `rd_data` MSB first, using the low byte in 8-bit mode.
- R8: After the last data bit of a write aimed at this node, or of a broadcast write, `wr_done` is 1 and `wr_data` holds the word, right-aligned in 8-bit mode. A write aimed elsewhere leaves `wr_done` at 0.
- R9: The reserved bit has no effect on selection or data and is forwarded on `sdi_thru` as received.
- R10: A high `cs_n` ends the frame at once. The bit position, borrow state, captured fields and output enable all clear, so a frame cut short leaves no effect on the next one.
- R11: While `rst_n` is low, all outputs are at their idle values: `sdo_oe`, `sdo`, `hdr_done`, `tgt_mask` and `wr_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock; data sampled on the rising edge |
| cs_n | input | 1 | Chip select, active low; high clears the frame state |
| sdi | input | 1 | Serial data from the host or the upstream device |
| len16 | input | 1 | Data length: 1 = 16-bit word, 0 = 8-bit word; stable during a frame |
| rd_data | input | 16 | Read word from the addressed channel's storage |
| sdi_thru | output | 1 | Serial data to the downstream device, channel number rewritten |
| sdo | output | 1 | Serial read data, 0 while not enabled |
| sdo_oe | output | 1 | Output enable for the shared return line |
| hdr_done | output | 1 | Header (command, channel, address) fully received |
| tgt_mask | output | 2 | One bit per local channel that the frame addresses |
| acc_read | output | 1 | Captured direction bit |
| acc_reg | output | 1 | Captured space select bit |
| acc_addr | output | 8 | Captured address |
| wr_data | output | 16 | Received data word |
| wr_done | output | 1 | Complete write for a local channel received |

## Verification
The bench aims at the wrap of the channel number: 0 and 1 must leave as 14 and 15. A borrow that is not reseeded at the first number bit, or not stopped by a one, would corrupt those values and misroute every device further down. Broadcast frames check that the number passes unchanged and that a broadcast read keeps the line floating, which a design that only checks the match would break by driving into contention. Reads in both lengths pin the first and last driven slots, so an enable one slot early or late shows as a wrong bit vector. A frame aborted inside the number field, then followed by a full read, exposes any borrow or bit position that survives the rise of chip select.

// File: rtl/spi_dc_pkg.sv
package spi_dc_pkg;

   // Command bits that precede the channel number, in arrival order.
   localparam int CTRL_BITS  = 4;
   localparam int SLOT_BCAST = 0;
   localparam int SLOT_DIR   = 1;
   localparam int SLOT_SPACE = 2;
   localparam int SLOT_RSV   = 3;

   typedef enum logic [2:0] {
      PH_CTRL = 3'd0,
      PH_ID   = 3'd1,
      PH_ADDR = 3'd2,
      PH_DATA = 3'd3,
      PH_DONE = 3'd4
   } phase_t;

endpackage

// File: rtl/dc_bit_counter.sv
module dc_bit_counter
   import spi_dc_pkg::*;
#(
   parameter int ID_W   = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 6
) (
   input  logic             clk,
   input  logic             arst,
   input  logic             len16,
   output logic [CNT_W-1:0] cnt,
   output phase_t           phase,
   output logic             id_first,
   output logic [CNT_W-1:0] data_idx
);

   localparam int HDR_BITS = CTRL_BITS + ID_W + ADDR_W;
   localparam int ID_END   = CTRL_BITS + ID_W;
   localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(HDR_BITS + DATA_W);
   localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(HDR_BITS + DATA_W / 2);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] frame_len;

   assign frame_len = len16 ? LEN_LONG : LEN_SHORT;

   // Position within the frame; parks at the frame length.
   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         cnt_q <= '0;
      end else if (cnt_q < frame_len) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      if (cnt_q < CNT_W'(CTRL_BITS)) begin
         phase = PH_CTRL;
      end else if (cnt_q < CNT_W'(ID_END)) begin
         phase = PH_ID;
      end else if (cnt_q < CNT_W'(HDR_BITS)) begin
         phase = PH_ADDR;
      end else if (cnt_q < frame_len) begin
         phase = PH_DATA;
      end else begin
         phase = PH_DONE;
      end
   end

   assign cnt      = cnt_q;
   assign id_first = (cnt_q == CNT_W'(CTRL_BITS));
   assign data_idx = cnt_q - CNT_W'(HDR_BITS);

endmodule

// File: rtl/dc_chan_stage.sv
module dc_chan_stage (
   input  logic clk,
   input  logic arst,
   input  logic bit_in,
   input  logic id_phase,
   input  logic id_first,
   input  logic bypass,
   output logic bit_out,
   output logic zero_seen
);

   logic borrow_q;
   logic borrow_in;
   logic zero_q;

   // The first number bit always subtracts one; later bits take the carried borrow.
   assign borrow_in = id_first ? 1'b1 : borrow_q;

   always_comb begin
      if (id_phase && !bypass) begin
         bit_out = bit_in ^ borrow_in;
      end else begin
         bit_out = bit_in;
      end
   end

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         borrow_q <= 1'b0;
         zero_q   <= 1'b1;
      end else if (id_phase) begin
         borrow_q <= borrow_in & ~bit_in;
         zero_q   <= zero_q & ~bit_in;
      end
   end

   assign zero_seen = zero_q;

endmodule

// File: rtl/dc_frame_ctl.sv
module dc_frame_ctl
   import spi_dc_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              arst,
   input  logic              sdi,
   input  logic [CNT_W-1:0]  cnt,
   input  phase_t            phase,
   input  logic [NUM_CH-1:0] zero_vec,
   output logic              bcast,
   output logic              dir_rd,
   output logic              space_reg,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] wdata,
   output logic [NUM_CH-1:0] tgt_mask,
   output logic              hdr_done,
   output logic              wr_done,
   output logic              rd_en
);

   logic              bcast_q;
   logic              dir_q;
   logic              space_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              id_known;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         bcast_q <= 1'b0;
         dir_q   <= 1'b0;
         space_q <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         case (phase)
            PH_CTRL: begin
               if (cnt == CNT_W'(SLOT_BCAST)) bcast_q <= sdi;
               if (cnt == CNT_W'(SLOT_DIR))   dir_q   <= sdi;
               if (cnt == CNT_W'(SLOT_SPACE)) space_q <= sdi;
               // The reserved slot is deliberately not captured.
            end
            PH_ADDR: addr_q  <= {addr_q[ADDR_W-2:0], sdi};
            PH_DATA: wdata_q <= {wdata_q[DATA_W-2:0], sdi};
            default: ;
         endcase
      end
   end

   assign id_known = (phase == PH_ADDR) || (phase == PH_DATA) || (phase == PH_DONE);
   assign hdr_done = (phase == PH_DATA) || (phase == PH_DONE);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_tgt
      assign tgt_mask[ch] = id_known && (bcast_q || zero_vec[ch]);
   end

   assign wr_done = (phase == PH_DONE) && !dir_q && (|tgt_mask);
   assign rd_en   = (phase == PH_DATA) && dir_q && !bcast_q && (|zero_vec);

   assign bcast     = bcast_q;
   assign dir_rd    = dir_q;
   assign space_reg = space_q;
   assign addr      = addr_q;
   assign wdata     = wdata_q;

endmodule

// File: rtl/dc_sdo_drive.sv
module dc_sdo_drive #(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 6
) (
   input  logic              rd_en,
   input  logic              len16,
   input  logic [CNT_W-1:0]  data_idx,
   input  logic [DATA_W-1:0] rd_data,
   output logic              sdo,
   output logic              sdo_oe
);

   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] shifted;
   logic              msb_bit;

   // Shifting instead of indexing keeps the select free of width mismatches.
   assign shifted = rd_data << data_idx;
   assign msb_bit = len16 ? shifted[DATA_W-1] : shifted[HALF_W-1];

   assign sdo_oe = rd_en;
   assign sdo    = rd_en & msb_bit;

endmodule

// File: rtl/daisy_spi_node.sv
module daisy_spi_node
   import spi_dc_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ID_W   = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              sdi,
   input  logic              len16,
   input  logic [DATA_W-1:0] rd_data,
   output logic              sdi_thru,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              hdr_done,
   output logic [NUM_CH-1:0] tgt_mask,
   output logic              acc_read,
   output logic              acc_reg,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_done
);

   localparam int HDR_BITS  = CTRL_BITS + ID_W + ADDR_W;
   localparam int FRAME_MAX = HDR_BITS + DATA_W;
   localparam int CNT_W     = $clog2(FRAME_MAX + 1);

   if (NUM_CH < 1 || NUM_CH >= (1 << ID_W)) begin : g_bad_num_ch
      $error("NUM_CH must be at least 1 and below the channel number range");
   end
   if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_data_w
      $error("DATA_W must be even and at least 2");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("ADDR_W must be at least 2");
   end
   if (ID_W < 1) begin : g_bad_id_w
      $error("ID_W must be at least 1");
   end

   logic             frame_rst;
   logic [CNT_W-1:0] cnt;
   phase_t           phase;
   logic             id_first;
   logic             id_phase;
   logic [CNT_W-1:0] data_idx;
   logic             bcast_q;
   logic             rd_en;
   logic [NUM_CH:0]  chain;
   logic [NUM_CH-1:0] zero_vec;

   // Deselect and global reset both end the frame asynchronously.
   assign frame_rst = ~rst_n | cs_n;
   assign id_phase  = (phase == PH_ID);

   dc_bit_counter #(
      .ID_W   (ID_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_cnt (
      .clk      (sclk),
      .arst     (frame_rst),
      .len16    (len16),
      .cnt      (cnt),
      .phase    (phase),
      .id_first (id_first),
      .data_idx (data_idx)
   );

   // One decrement stage per local channel, chained in order.
   assign chain[0] = sdi;
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_stage
      dc_chan_stage u_stage (
         .clk       (sclk),
         .arst      (frame_rst),
         .bit_in    (chain[ch]),
         .id_phase  (id_phase),
         .id_first  (id_first),
         .bypass    (bcast_q),
         .bit_out   (chain[ch+1]),
         .zero_seen (zero_vec[ch])
      );
   end
   assign sdi_thru = chain[NUM_CH];

   dc_frame_ctl #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_ctl (
      .clk       (sclk),
      .arst      (frame_rst),
      .sdi       (sdi),
      .cnt       (cnt),
      .phase     (phase),
      .zero_vec  (zero_vec),
      .bcast     (bcast_q),
      .dir_rd    (acc_read),
      .space_reg (acc_reg),
      .addr      (acc_addr),
      .wdata     (wr_data),
      .tgt_mask  (tgt_mask),
      .hdr_done  (hdr_done),
      .wr_done   (wr_done),
      .rd_en     (rd_en)
   );

   dc_sdo_drive #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_sdo (
      .rd_en    (rd_en),
      .len16    (len16),
      .data_idx (data_idx),
      .rd_data  (rd_data),
      .sdo      (sdo),
      .sdo_oe   (sdo_oe)
   );

endmodule

// File: rtl/dc_node_checker.sv
module dc_node_checker #(
   parameter int NUM_CH = 2
) (
   input logic              sclk,
   input logic              frame_rst,
   input logic              sdi,
   input logic              sdi_thru,
   input logic              sdo,
   input logic              sdo_oe,
   input logic              hdr_done,
   input logic [NUM_CH-1:0] tgt_mask,
   input logic              acc_read,
   input logic              wr_done,
   input logic              bcast_q
);

   // R6: the return line stays floating while the header streams in
   a_r6_hiz_in_header: assert property (@(posedge sclk) disable iff (frame_rst)
      !hdr_done |-> !sdo_oe);

   // R6: nothing is presented on sdo unless it is enabled
   a_r6_sdo_quiet: assert property (@(posedge sclk) disable iff (frame_rst)
      !sdo_oe |-> !sdo);

   // R5 and R7: driving only for a local, non-broadcast read
   a_r5_drive_only_local_read: assert property (@(posedge sclk) disable iff (frame_rst)
      sdo_oe |-> (acc_read && !bcast_q && (|tgt_mask)));

   // R3: a directed frame addresses at most one local channel
   a_r3_single_target: assert property (@(posedge sclk) disable iff (frame_rst)
      !bcast_q |-> $onehot0(tgt_mask));

   // R2: once the header is in, the stream is copied unchanged
   a_r2_copy_after_header: assert property (@(posedge sclk) disable iff (frame_rst)
      hdr_done |-> (sdi_thru == sdi));

   // R4: a broadcast frame is forwarded without any rewrite
   a_r4_bcast_copy: assert property (@(posedge sclk) disable iff (frame_rst)
      bcast_q |-> (sdi_thru == sdi));

   // R8: completion is flagged for writes only
   a_r8_done_is_write: assert property (@(posedge sclk) disable iff (frame_rst)
      wr_done |-> !acc_read);

endmodule

bind daisy_spi_node dc_node_checker #(.NUM_CH(NUM_CH)) u_chk (
   .sclk      (sclk),
   .frame_rst (frame_rst),
   .sdi       (sdi),
   .sdi_thru  (sdi_thru),
   .sdo       (sdo),
   .sdo_oe    (sdo_oe),
   .hdr_done  (hdr_done),
   .tgt_mask  (tgt_mask),
   .acc_read  (acc_read),
   .wr_done   (wr_done),
   .bcast_q   (bcast_q)
);

// File: tb/daisy_spi_node_tb.sv
module daisy_spi_node_tb;

   localparam int CLK_PERIOD = 62;
   localparam int WATCHDOG   = 200000;

   logic        rst_n;
   logic        sclk;
   logic        cs_n;
   logic        sdi;
   logic        len16;
   logic [15:0] rd_data;
   logic        sdi_thru;
   logic        sdo;
   logic        sdo_oe;
   logic        hdr_done;
   logic [1:0]  tgt_mask;
   logic        acc_read;
   logic        acc_reg;
   logic [7:0]  acc_addr;
   logic [15:0] wr_data;
   logic        wr_done;

   int checks = 0;
   int errors = 0;

   logic [31:0] fbits;
   logic [31:0] got_thru, got_oe, got_sdo;
   int          flen;

   daisy_spi_node u_dut (
      .rst_n    (rst_n),
      .sclk     (sclk),
      .cs_n     (cs_n),
      .sdi      (sdi),
      .len16    (len16),
      .rd_data  (rd_data),
      .sdi_thru (sdi_thru),
      .sdo      (sdo),
      .sdo_oe   (sdo_oe),
      .hdr_done (hdr_done),
      .tgt_mask (tgt_mask),
      .acc_read (acc_read),
      .acc_reg  (acc_reg),
      .acc_addr (acc_addr),
      .wr_data  (wr_data),
      .wr_done  (wr_done)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Frame bits per R1: slot i holds bit i of fbits.
   task automatic build(input logic bc, input logic rw, input logic rg, input logic rsv,
                        input logic [3:0] id, input logic [7:0] addr,
                        input logic [15:0] data, input logic l16);
      int dl;
      dl = l16 ? 16 : 8;
      fbits = '0;
      fbits[0] = bc;
      fbits[1] = rw;
      fbits[2] = rg;
      fbits[3] = rsv;
      for (int k = 0; k < 4; k++) fbits[4+k] = id[k];
      for (int k = 0; k < 8; k++) fbits[8+k] = addr[7-k];
      for (int k = 0; k < dl; k++) fbits[16+k] = data[dl-1-k];
      flen = 16 + dl;
   endtask

   task automatic shift_bits(input int nbits);
      got_thru = '0;
      got_oe   = '0;
      got_sdo  = '0;
      for (int i = 0; i < nbits; i++) begin
         sdi = fbits[i];
         #(CLK_PERIOD/4);
         got_thru[i] = sdi_thru;
         got_oe[i]   = sdo_oe;
         got_sdo[i]  = sdo;
         #(CLK_PERIOD/4);
         sclk = 1'b1;
         #(CLK_PERIOD/2);
         sclk = 1'b0;
      end
   endtask

   task automatic start_frame(input logic l16, input logic [15:0] rdv);
      len16   = l16;
      rd_data = rdv;
      #(CLK_PERIOD/2);
      cs_n = 1'b0;
      #(CLK_PERIOD/2);
   endtask

   task automatic end_frame();
      sdi = 1'b0;
      #(CLK_PERIOD/2);
      cs_n = 1'b1;
      #(CLK_PERIOD);
   endtask

   // Runs a full frame and checks every requirement-level outcome.
   task automatic run_and_check(input string tag,
                                input logic bc, input logic rw, input logic rg, input logic rsv,
                                input logic [3:0] id, input logic [7:0] addr,
                                input logic [15:0] data, input logic l16,
                                input logic [15:0] rdv);
      logic [31:0] exp_thru, exp_oe, exp_sdo;
      logic [3:0]  idm2;
      logic [1:0]  exp_mask;
      logic        local_read;
      int          dl;
      build(bc, rw, rg, rsv, id, addr, data, l16);
      dl = l16 ? 16 : 8;
      start_frame(l16, rdv);
      shift_bits(flen);

      idm2     = id - 4'd2;
      exp_thru = fbits;
      if (!bc) for (int k = 0; k < 4; k++) exp_thru[4+k] = idm2[k];
      exp_mask   = bc ? 2'b11 : (id == 4'd0) ? 2'b01 : (id == 4'd1) ? 2'b10 : 2'b00;
      local_read = rw && !bc && (exp_mask != 2'b00);
      exp_oe  = '0;
      exp_sdo = '0;
      if (local_read) begin
         for (int k = 0; k < dl; k++) begin
            exp_oe[16+k]  = 1'b1;
            exp_sdo[16+k] = rdv[dl-1-k];
         end
      end

      chk({tag, " R2 R4 R9"}, "sdi_thru stream", got_thru, exp_thru);
      chk({tag, " R5 R6 R7"}, "sdo_oe slots", got_oe, exp_oe);
      chk({tag, " R6 R7"}, "sdo stream", got_sdo, exp_sdo);
      chk({tag, " R3 R4"}, "tgt_mask", {30'd0, tgt_mask}, {30'd0, exp_mask});
      chk({tag, " R1"}, "acc_read", {31'd0, acc_read}, {31'd0, rw});
      chk({tag, " R1"}, "acc_reg", {31'd0, acc_reg}, {31'd0, rg});
      chk({tag, " R1"}, "acc_addr", {24'd0, acc_addr}, {24'd0, addr});
      chk({tag, " R8"}, "wr_done", {31'd0, wr_done},
          {31'd0, (!rw && exp_mask != 2'b00)});
      if (!rw) chk({tag, " R8"}, "wr_data", {16'd0, wr_data},
                   {16'd0, (l16 ? data : {8'd0, data[7:0]})});
      chk({tag, " R6"}, "sdo_oe after data", {31'd0, sdo_oe}, 32'd0);
      end_frame();
   endtask

   task automatic t_reset_state();
      sdi = 1'b1;
      #(CLK_PERIOD/4);
      chk("R11", "sdo_oe in reset", {31'd0, sdo_oe}, 32'd0);
      chk("R11", "sdo in reset", {31'd0, sdo}, 32'd0);
      chk("R11", "hdr_done in reset", {31'd0, hdr_done}, 32'd0);
      chk("R11", "tgt_mask in reset", {30'd0, tgt_mask}, 32'd0);
      chk("R11", "wr_done in reset", {31'd0, wr_done}, 32'd0);
      chk("R11 R2", "sdi_thru copies sdi in reset", {31'd0, sdi_thru}, 32'd1);
      sdi = 1'b0;
   endtask

   task automatic t_write_local();
      run_and_check("write ch0", 1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 8'h5A, 16'hBEEF, 1'b1, 16'h0);
      run_and_check("write ch1 ram 8b", 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 8'h11, 16'h003C, 1'b0, 16'h0);
   endtask

   task automatic t_write_remote();
      run_and_check("write id7", 1'b0, 1'b0, 1'b1, 1'b0, 4'd7, 8'hC3, 16'h1234, 1'b1, 16'h0);
      run_and_check("write id15", 1'b0, 1'b0, 1'b0, 1'b0, 4'd15, 8'h80, 16'h0081, 1'b0, 16'h0);
   endtask

   task automatic t_read_local();
      run_and_check("read ch0 16b", 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 8'h01, 16'h0, 1'b1, 16'hA5C3);
      run_and_check("read ch1 8b", 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 8'hFE, 16'h0, 1'b0, 16'h12C6);
   endtask

   task automatic t_read_remote();
      run_and_check("read id3", 1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 8'h3F, 16'h0, 1'b1, 16'hFFFF);
   endtask

   task automatic t_broadcast();
      run_and_check("bcast write", 1'b1, 1'b0, 1'b1, 1'b0, 4'd9, 8'h44, 16'h007E, 1'b0, 16'h0);
      run_and_check("bcast read", 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 8'h22, 16'h0, 1'b1, 16'hFFFF);
   endtask

   task automatic t_reserved();
      run_and_check("reserved set R9", 1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 8'h5A, 16'hBEEF, 1'b1, 16'h0);
      run_and_check("reserved set read R9", 1'b0, 1'b1, 1'b1, 1'b1, 4'd1, 8'h07, 16'h0, 1'b1, 16'h8001);
   endtask

   task automatic t_abort();
      // Stop inside the channel number: borrow and position must not survive.
      build(1'b0, 1'b1, 1'b1, 1'b0, 4'd6, 8'h00, 16'h0, 1'b1);
      start_frame(1'b1, 16'h0);
      shift_bits(6);
      end_frame();
      chk("R10", "hdr_done after abort", {31'd0, hdr_done}, 32'd0);
      chk("R10", "sdo_oe after abort", {31'd0, sdo_oe}, 32'd0);
      chk("R10", "tgt_mask after abort", {30'd0, tgt_mask}, 32'd0);
      chk("R10", "acc_read after abort", {31'd0, acc_read}, 32'd0);
      run_and_check("read after abort R10", 1'b0, 1'b1, 1'b1, 1'b0, 4'd1, 8'h9C, 16'h0, 1'b1, 16'h6D2B);
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n   = 1'b0;
      sclk    = 1'b0;
      cs_n    = 1'b1;
      sdi     = 1'b0;
      len16   = 1'b1;
      rd_data = 16'h0;
      #(CLK_PERIOD * 2);
      t_reset_state();
      rst_n = 1'b1;
      #(CLK_PERIOD * 2);
      t_write_local();
      t_write_remote();
      t_read_local();
      t_read_remote();
      t_broadcast();
      t_reserved();
      t_abort();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule